// File: doc/BRIEF.md
# Auto-Increment Buffer Access Port

This block lets a host reach a 2 KB packet buffer through four byte-wide I/O registers. The buffer is split into four 512-byte pages. Two registers hold a 16-bit pointer. A data register gives a window onto the buffer at that pointer. Every time the pointer changes, the window is refilled with the two buffer bytes at the pointer and at the pointer plus one. A read or a write through the window can then move the pointer on by itself. Pointer bit 14 turns this advance on, and the step is one byte for an 8-bit access or two bytes for a 16-bit access.

The buffer is one dual-port synchronous RAM. The host side uses port A only. Port B is brought out unchanged so that the packet datapath can fill and drain pages. A small state machine runs port A:
- `ST_IDLE` accepts a request. A write to the data window goes to `ST_WR_LO`; a pointer write or a data-window read goes to `ST_PF_LO`; every other access stays in `ST_IDLE`.
- `ST_WR_LO` stores the low byte. It goes to `ST_WR_HI` for a 16-bit write, or to `ST_PF_LO` after advancing the pointer.
- `ST_WR_HI` stores the high byte, advances the pointer and goes to `ST_PF_LO`.
- `ST_PF_LO` reads the byte at the pointer and goes to `ST_PF_HI`.
- `ST_PF_HI` reads the next byte, captures the low byte and goes to `ST_PF_END`.
- `ST_PF_END` captures the high byte and returns to `ST_IDLE`.

While the state machine is outside `ST_IDLE`, `busy` is high. If `req_wr` and `req_rd` are both high in the same cycle, the write is taken.

Top module: `bap_top`

## Requirements
- R1: After reset the pointer and the data window are zero, `busy` is low and `rd_valid` is low.
- R2: The pointer low byte is at offset 0xE and the high byte at 0xF, and both read back. Writing either byte refills the data window: low half = buffer[ptr[10:0]], high half = buffer[(ptr[10:0]+1) mod 2048]. `busy` stays high until the refill is done.
- R3: An 8-bit read of offset 0xC returns {8'h00, window low byte}, with `rd_valid` high one cycle after the request. The pointer then advances by 1 if auto-increment is on, and the window is refilled.
- R4: An 8-bit write to offset 0xC stores `req_wdata[7:0]` at buffer[ptr[10:0]]. The pointer then advances by 1 if auto-increment is on, and the window is refilled.
- R5: With pointer bit 14 clear, data-window accesses leave the pointer unchanged.
- R6: An advance writes a pointer with bit 14 set, bits 15 and 13:11 cleared, and offset (ptr[10:0] + step) mod 2048.
- R7: A 16-bit access is taken when `req_wide` and `wide_en` are both high and the offset is 0xC. A read returns the full window, {buffer[p+1], buffer[p]}. A write stores `req_wdata[7:0]` at p and `req_wdata[15:8]` at (p+1) mod 2048. The step is 2.
- R8: A 16-bit request while `wide_en` is low acts exactly like an 8-bit access.
- R9: Offset 0xD reads {8'h00, window high byte} and does not advance the pointer. A write to 0xD replaces only the window high byte: no buffer write and no refill.
- R10: Offsets 0x0 to 0xB read as 16'h00AA. Writes to them change neither the pointer, nor the window, nor the buffer.
- R11: A request made while `busy` is high is ignored.
- R12: Port B writes the buffer, and returns buffer[pk_addr] one cycle after a read request. Host accesses through port A see data written on port B, and port B sees data written by the host.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_rd | input | 1 | Host register read request |
| req_wr | input | 1 | Host register write request |
| req_ofs | input | 4 | Register offset |
| req_wide | input | 1 | Request a 16-bit access |
| req_wdata | input | 16 | Write data (8-bit accesses use bits 7:0) |
| wide_en | input | 1 | Allows 16-bit access to the data window |
| rd_valid | output | 1 | Read data valid, a one-cycle pulse |
| rd_data | output | 16 | Read data |
| busy | output | 1 | A write or a refill is in progress |
| pk_en | input | 1 | Port B enable |
| pk_we | input | 1 | Port B write enable |
| pk_addr | input | 11 | Port B byte address |
| pk_wdata | input | 8 | Port B write byte |
| pk_rdata | output | 8 | Port B read byte |

## Verification
Some properties are checked on every cycle:
- the refill order;
- the pointer staying still during a refill;
- the auto-increment flag surviving an advance with the other high bits cleared;
- a pointer with auto-increment off holding still;
- no read being accepted while busy;
- the 0xAA pattern for unmapped offsets.

Other behaviours need the bench scenarios, because they depend on buffer contents and on the order of operations:
- wrap of the second byte at the top of the buffer;
- a 16-bit write landing both bytes;
- a high-byte write skipping the buffer;
- requests made during busy being dropped.

// File: rtl/bap_pkg.sv
package bap_pkg;
    localparam int PTR_W = 16;
    localparam logic [3:0] OFS_DATA_LO = 4'hC;
    localparam logic [3:0] OFS_DATA_HI = 4'hD;
    localparam logic [3:0] OFS_PTR_LO  = 4'hE;
    localparam logic [3:0] OFS_PTR_HI  = 4'hF;
    localparam logic [7:0] UNMAPPED_RD = 8'hAA;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_LO,
        ST_WR_HI,
        ST_PF_LO,
        ST_PF_HI,
        ST_PF_END
    } bap_state_e;
endpackage

// File: rtl/bap_dpram.sv
module bap_dpram #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          a_en,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    input  logic          b_en,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store_q [DEPTH];

    // Port B write is applied second, so it wins a same-address collision
    always_ff @(posedge clk) begin
        if (a_en && a_we) store_q[a_addr] <= a_wdata;
        if (b_en && b_we) store_q[b_addr] <= b_wdata;
    end

    always_ff @(posedge clk) begin
        if (a_en) a_rdata <= store_q[a_addr];
        if (b_en) b_rdata <= store_q[b_addr];
    end
endmodule

// File: rtl/bap_pointer.sv
module bap_pointer
    import bap_pkg::*;
#(
    parameter int BUF_AW   = 11,
    parameter int AUTO_BIT = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [7:0]        wbyte,
    input  logic              adv,
    input  logic [1:0]        step,
    output logic [PTR_W-1:0]  ptr,
    output logic [BUF_AW-1:0] off,
    output logic [BUF_AW-1:0] off_nx
);
    logic [PTR_W-1:0] adv_val;

    assign off    = ptr[BUF_AW-1:0];
    assign off_nx = off + BUF_AW'(1);

    always_comb begin
        adv_val = '0;
        adv_val[AUTO_BIT] = 1'b1;
        adv_val[BUF_AW-1:0] = off + BUF_AW'(step);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (wr_lo) begin
            ptr[7:0] <= wbyte;
        end else if (wr_hi) begin
            ptr[PTR_W-1:8] <= wbyte;
        end else if (adv && ptr[AUTO_BIT]) begin
            ptr <= adv_val;
        end
    end

    AST_AUTO_FLAG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && ptr[AUTO_BIT] && !wr_lo && !wr_hi) |=> (ptr[AUTO_BIT] && ptr[13:11] == 3'b000 && !ptr[15])); // R6

    AST_NO_ADV_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !ptr[AUTO_BIT] && !wr_lo && !wr_hi) |=> $stable(ptr)); // R5
endmodule

// File: rtl/bap_fsm.sv
module bap_fsm
    import bap_pkg::*;
#(
    parameter int BUF_AW = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic [3:0]        req_ofs,
    input  logic              req_wide,
    input  logic [15:0]       req_wdata,
    input  logic              wide_en,
    input  logic [PTR_W-1:0]  ptr_i,
    input  logic [BUF_AW-1:0] ptr_off,
    input  logic [BUF_AW-1:0] ptr_off_nx,
    output logic              ptr_wr_lo,
    output logic              ptr_wr_hi,
    output logic              ptr_adv,
    output logic [1:0]        ptr_step,
    output logic              ram_en,
    output logic              ram_we,
    output logic [BUF_AW-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    input  logic [7:0]        ram_rdata,
    output logic              rd_valid,
    output logic [15:0]       rd_data,
    output logic              busy
);
    bap_state_e state, state_nx;
    logic [15:0] window_q;
    logic        wide_q;
    logic        wide_go;
    logic        idle;

    assign idle    = (state == ST_IDLE);
    assign busy    = !idle;
    assign wide_go = req_wide && wide_en && (req_ofs == OFS_DATA_LO);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next state and port-A / pointer controls
    always_comb begin
        state_nx  = state;
        ptr_wr_lo = 1'b0;
        ptr_wr_hi = 1'b0;
        ptr_adv   = 1'b0;
        ptr_step  = 2'd1;
        ram_en    = 1'b0;
        ram_we    = 1'b0;
        ram_addr  = '0;
        ram_wdata = '0;
        unique case (state)
            ST_IDLE: begin
                if (req_wr) begin
                    unique case (req_ofs)
                        OFS_DATA_LO: state_nx = ST_WR_LO;
                        OFS_PTR_LO: begin
                            ptr_wr_lo = 1'b1;
                            state_nx  = ST_PF_LO;
                        end
                        OFS_PTR_HI: begin
                            ptr_wr_hi = 1'b1;
                            state_nx  = ST_PF_LO;
                        end
                        default: state_nx = ST_IDLE;
                    endcase
                end else if (req_rd && req_ofs == OFS_DATA_LO) begin
                    ptr_adv  = 1'b1;
                    ptr_step = wide_go ? 2'd2 : 2'd1;
                    state_nx = ST_PF_LO;
                end
            end
            ST_WR_LO: begin
                ram_en    = 1'b1;
                ram_we    = 1'b1;
                ram_addr  = ptr_off;
                ram_wdata = window_q[7:0];
                if (wide_q) begin
                    state_nx = ST_WR_HI;
                end else begin
                    ptr_adv  = 1'b1;
                    ptr_step = 2'd1;
                    state_nx = ST_PF_LO;
                end
            end
            ST_WR_HI: begin
                ram_en    = 1'b1;
                ram_we    = 1'b1;
                ram_addr  = ptr_off_nx;
                ram_wdata = window_q[15:8];
                ptr_adv   = 1'b1;
                ptr_step  = 2'd2;
                state_nx  = ST_PF_LO;
            end
            ST_PF_LO: begin
                ram_en   = 1'b1;
                ram_addr = ptr_off;
                state_nx = ST_PF_HI;
            end
            ST_PF_HI: begin
                ram_en   = 1'b1;
                ram_addr = ptr_off_nx;
                state_nx = ST_PF_END;
            end
            ST_PF_END: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Data window and read-return registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            window_q <= '0;
            wide_q   <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= 1'b0;
            if (idle) begin
                if (req_wr) begin
                    if (req_ofs == OFS_DATA_LO) begin
                        wide_q <= wide_go;
                        if (wide_go) window_q <= req_wdata;
                        else         window_q[7:0] <= req_wdata[7:0];
                    end else if (req_ofs == OFS_DATA_HI) begin
                        window_q[15:8] <= req_wdata[7:0];
                    end
                end else if (req_rd) begin
                    rd_valid <= 1'b1;
                    unique case (req_ofs)
                        OFS_DATA_LO: rd_data <= wide_go ? window_q : {8'h00, window_q[7:0]};
                        OFS_DATA_HI: rd_data <= {8'h00, window_q[15:8]};
                        OFS_PTR_LO:  rd_data <= {8'h00, ptr_i[7:0]};
                        OFS_PTR_HI:  rd_data <= {8'h00, ptr_i[15:8]};
                        default:     rd_data <= {8'h00, UNMAPPED_RD};
                    endcase
                end
            end else if (state == ST_PF_HI) begin
                window_q[7:0] <= ram_rdata;
            end else if (state == ST_PF_END) begin
                window_q[15:8] <= ram_rdata;
            end
        end
    end

    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !rd_valid); // R11

    AST_PREFETCH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PF_LO) |=> (state == ST_PF_HI)); // R2

    AST_PTR_HELD_IN_PF: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PF_HI || state == ST_PF_END) |-> $stable(ptr_i)); // R2

    AST_UNMAPPED_AA: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(req_ofs) < OFS_DATA_LO) |-> (rd_data == {8'h00, UNMAPPED_RD})); // R10
endmodule

// File: rtl/bap_top.sv
module bap_top
    import bap_pkg::*;
#(
    parameter int BUF_AW   = 11,
    parameter int AUTO_BIT = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic [3:0]        req_ofs,
    input  logic              req_wide,
    input  logic [15:0]       req_wdata,
    input  logic              wide_en,
    output logic              rd_valid,
    output logic [15:0]       rd_data,
    output logic              busy,
    input  logic              pk_en,
    input  logic              pk_we,
    input  logic [BUF_AW-1:0] pk_addr,
    input  logic [7:0]        pk_wdata,
    output logic [7:0]        pk_rdata
);
    logic [PTR_W-1:0]  ptr;
    logic [BUF_AW-1:0] ptr_off, ptr_off_nx;
    logic              ptr_wr_lo, ptr_wr_hi, ptr_adv;
    logic [1:0]        ptr_step;
    logic              ram_en, ram_we;
    logic [BUF_AW-1:0] ram_addr;
    logic [7:0]        ram_wdata, ram_rdata;

    bap_pointer #(.BUF_AW(BUF_AW), .AUTO_BIT(AUTO_BIT)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_lo  (ptr_wr_lo),
        .wr_hi  (ptr_wr_hi),
        .wbyte  (req_wdata[7:0]),
        .adv    (ptr_adv),
        .step   (ptr_step),
        .ptr    (ptr),
        .off    (ptr_off),
        .off_nx (ptr_off_nx)
    );

    bap_fsm #(.BUF_AW(BUF_AW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_rd     (req_rd),
        .req_wr     (req_wr),
        .req_ofs    (req_ofs),
        .req_wide   (req_wide),
        .req_wdata  (req_wdata),
        .wide_en    (wide_en),
        .ptr_i      (ptr),
        .ptr_off    (ptr_off),
        .ptr_off_nx (ptr_off_nx),
        .ptr_wr_lo  (ptr_wr_lo),
        .ptr_wr_hi  (ptr_wr_hi),
        .ptr_adv    (ptr_adv),
        .ptr_step   (ptr_step),
        .ram_en     (ram_en),
        .ram_we     (ram_we),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata),
        .ram_rdata  (ram_rdata),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .busy       (busy)
    );

    bap_dpram #(.AW(BUF_AW), .DW(8)) u_ram (
        .clk     (clk),
        .a_en    (ram_en),
        .a_we    (ram_we),
        .a_addr  (ram_addr),
        .a_wdata (ram_wdata),
        .a_rdata (ram_rdata),
        .b_en    (pk_en),
        .b_we    (pk_we),
        .b_addr  (pk_addr),
        .b_wdata (pk_wdata),
        .b_rdata (pk_rdata)
    );
endmodule

// File: tb/tb_bap_top.sv
module tb_bap_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_rd = 1'b0, req_wr = 1'b0, req_wide = 1'b0, wide_en = 1'b0;
    logic [3:0]  req_ofs = 4'h0;
    logic [15:0] req_wdata = 16'h0;
    logic        rd_valid, busy;
    logic [15:0] rd_data;
    logic        pk_en = 1'b0, pk_we = 1'b0;
    logic [10:0] pk_addr = 11'h0;
    logic [7:0]  pk_wdata = 8'h0;
    logic [7:0]  pk_rdata;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0]  mm [2048];
    logic [15:0] mptr = 16'h0;
    logic [15:0] mwin = 16'h0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bap_top dut (
        .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr), .req_ofs(req_ofs),
        .req_wide(req_wide), .req_wdata(req_wdata), .wide_en(wide_en),
        .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy),
        .pk_en(pk_en), .pk_we(pk_we), .pk_addr(pk_addr), .pk_wdata(pk_wdata), .pk_rdata(pk_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void m_refill();
        logic [10:0] o;
        o = mptr[10:0];
        mwin = {mm[o + 11'd1], mm[o]};
    endfunction

    function automatic void m_adv(input int step);
        if (mptr[14]) mptr = 16'h4000 | {5'b0, 11'(mptr[10:0] + 11'(step))};
    endfunction

    function automatic logic [15:0] m_read(input logic [3:0] ofs, input logic wd);
        logic [15:0] r;
        logic w;
        w = wd && wide_en && ofs == 4'hC;
        case (ofs)
            4'hC: begin
                r = w ? mwin : {8'h00, mwin[7:0]};
                m_adv(w ? 2 : 1);
                m_refill();
            end
            4'hD: r = {8'h00, mwin[15:8]};
            4'hE: r = {8'h00, mptr[7:0]};
            4'hF: r = {8'h00, mptr[15:8]};
            default: r = 16'h00AA;
        endcase
        return r;
    endfunction

    function automatic void m_write(input logic [3:0] ofs, input logic wd, input logic [15:0] v);
        logic w;
        logic [10:0] o;
        w = wd && wide_en && ofs == 4'hC;
        o = mptr[10:0];
        case (ofs)
            4'hC: begin
                mm[o] = v[7:0];
                if (w) mm[o + 11'd1] = v[15:8];
                m_adv(w ? 2 : 1);
                m_refill();
            end
            4'hD: mwin[15:8] = v[7:0];
            4'hE: begin mptr[7:0] = v[7:0]; m_refill(); end
            4'hF: begin mptr[15:8] = v[7:0]; m_refill(); end
            default: ;
        endcase
    endfunction

    task automatic bus(input logic wr, input logic [3:0] ofs, input logic wd,
                       input logic [15:0] v, output logic [15:0] got, output logic vld);
        @(negedge clk);
        req_wr = wr; req_rd = !wr; req_ofs = ofs; req_wide = wd; req_wdata = v;
        @(negedge clk);
        req_wr = 1'b0; req_rd = 1'b0;
        got = rd_data; vld = rd_valid;
        while (busy) @(negedge clk);
    endtask

    task automatic do_wr(input logic [3:0] ofs, input logic wd, input logic [15:0] v);
        logic [15:0] g;
        logic vl;
        m_write(ofs, wd, v);
        bus(1'b1, ofs, wd, v, g, vl);
    endtask

    task automatic do_rd(input string tag, input logic [3:0] ofs, input logic wd);
        logic [15:0] g, e;
        logic vl;
        e = m_read(ofs, wd);
        bus(1'b0, ofs, wd, 16'h0, g, vl);
        chk({tag, " rd_valid"}, {31'b0, vl}, 32'd1);
        chk(tag, {16'h0, g}, {16'h0, e});
    endtask

    task automatic set_ptr(input logic [15:0] p);
        do_wr(4'hF, 1'b0, {8'h00, p[15:8]});
        do_wr(4'hE, 1'b0, {8'h00, p[7:0]});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] g;
        logic vl;
        logic [15:0] saved_ptr;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        chk("R1 busy in reset", {31'b0, busy}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", {31'b0, busy}, 32'd0);
        chk("R1 rd_valid", {31'b0, rd_valid}, 32'd0);
        do_rd("R1 ptr lo", 4'hE, 1'b0);
        do_rd("R1 ptr hi", 4'hF, 1'b0);
        do_rd("R1 window hi", 4'hD, 1'b0);

        // R12: fill the buffer through port B
        for (int i = 0; i < 2048; i++) begin
            @(negedge clk);
            pk_en = 1'b1; pk_we = 1'b1; pk_addr = 11'(i); pk_wdata = 8'($urandom);
            mm[i] = pk_wdata;
        end
        @(negedge clk);
        pk_en = 1'b0; pk_we = 1'b0;
        for (int i = 0; i < 6; i++) begin
            logic [10:0] a;
            a = 11'($urandom);
            @(negedge clk);
            pk_en = 1'b1; pk_addr = a;
            @(negedge clk);
            pk_en = 1'b0;
            chk("R12 port B read", {24'h0, pk_rdata}, {24'h0, mm[a]});
        end

        // R2 / R6 / R7: wide read at the top of the buffer wraps
        wide_en = 1'b1;
        set_ptr(16'h47FE);
        do_rd("R2 window hi after ptr write", 4'hD, 1'b0);
        do_rd("R7 wide read at 0x7FE", 4'hC, 1'b1);
        do_rd("R6 ptr lo after wrap", 4'hE, 1'b0);
        do_rd("R6 ptr hi after wrap", 4'hF, 1'b0);

        // R6: stray high bits cleared by an advance
        set_ptr(16'hFFFF);
        do_rd("R3 narrow read at 0x7FF", 4'hC, 1'b0);
        do_rd("R6 ptr hi cleared", 4'hF, 1'b0);
        do_rd("R6 ptr lo wrapped", 4'hE, 1'b0);

        // R7: wide write straddling the top
        set_ptr(16'h47FF);
        do_wr(4'hC, 1'b1, 16'hBEEF);
        do_rd("R7 ptr lo after wide write", 4'hE, 1'b0);
        set_ptr(16'h47FF);
        do_rd("R7 wide readback", 4'hC, 1'b1);

        // R4: narrow write then readback
        set_ptr(16'h4123);
        do_wr(4'hC, 1'b0, 16'h005A);
        set_ptr(16'h4123);
        do_rd("R4 narrow readback", 4'hC, 1'b0);

        // R5: auto-increment off
        set_ptr(16'h0123);
        do_rd("R5 read one", 4'hC, 1'b0);
        do_rd("R5 read two", 4'hC, 1'b0);
        do_rd("R5 ptr lo held", 4'hE, 1'b0);
        do_wr(4'hC, 1'b0, 16'h00C3);
        do_rd("R5 ptr lo held after write", 4'hE, 1'b0);
        do_rd("R5 written byte", 4'hC, 1'b0);

        // R8: wide request with wide_en low
        wide_en = 1'b0;
        set_ptr(16'h4200);
        do_rd("R8 wide request gated", 4'hC, 1'b1);
        do_rd("R8 ptr advanced by one", 4'hE, 1'b0);
        wide_en = 1'b1;

        // R9: high window byte write does not touch the buffer
        set_ptr(16'h0300);
        do_wr(4'hD, 1'b0, 16'h0077);
        do_rd("R9 window hi written", 4'hD, 1'b0);
        do_rd("R9 ptr unchanged by hi read", 4'hE, 1'b0);
        do_wr(4'hE, 1'b0, 16'h0000);
        do_rd("R9 buffer next byte untouched", 4'hD, 1'b0);

        // R10: unmapped offsets
        do_rd("R10 unmapped read 3", 4'h3, 1'b0);
        do_rd("R10 unmapped wide read B", 4'hB, 1'b1);
        do_wr(4'h5, 1'b0, 16'h0099);
        do_wr(4'h0, 1'b1, 16'h1234);
        do_rd("R10 ptr after unmapped write", 4'hE, 1'b0);
        do_rd("R10 window after unmapped write", 4'hD, 1'b0);

        // R11: request during busy dropped
        m_write(4'hE, 1'b0, 16'h0010);
        @(negedge clk);
        req_wr = 1'b1; req_ofs = 4'hE; req_wdata = 16'h0010;
        @(negedge clk);
        req_wdata = 16'h0044;
        chk("R11 busy after accept", {31'b0, busy}, 32'd1);
        @(negedge clk);
        req_wr = 1'b0;
        while (busy) @(negedge clk);
        do_rd("R11 busy request ignored", 4'hE, 1'b0);
        saved_ptr = mptr;
        @(negedge clk);
        req_wr = 1'b1; req_ofs = 4'hC; req_wdata = 16'h00AB;
        m_write(4'hC, 1'b0, 16'h00AB);
        @(negedge clk);
        req_wr = 1'b0; req_rd = 1'b1; req_ofs = 4'hE;
        @(negedge clk);
        req_rd = 1'b0;
        chk("R11 no read during busy", {31'b0, rd_valid}, 32'd0);
        while (busy) @(negedge clk);
        do_rd("R11 ptr lo", 4'hE, 1'b0);
        chk("R11 ptr model", {16'h0, mptr}, {16'h0, saved_ptr});

        // R12: host write seen on port B
        set_ptr(16'h0555);
        do_wr(4'hC, 1'b0, 16'h003C);
        @(negedge clk);
        pk_en = 1'b1; pk_we = 1'b0; pk_addr = 11'h555;
        @(negedge clk);
        pk_en = 1'b0;
        chk("R12 port B sees host write", {24'h0, pk_rdata}, 32'h3C);

        // Random mix
        for (int k = 0; k < 700; k++) begin
            int sel;
            logic [3:0] ofs;
            logic wd;
            logic [15:0] v;
            sel = int'($urandom % 10);
            case (sel)
                0, 1, 2: ofs = 4'hC;
                3:       ofs = 4'hD;
                4:       ofs = 4'hE;
                5:       ofs = 4'hF;
                6:       ofs = 4'(($urandom % 12));
                default: ofs = 4'hC;
            endcase
            wd = 1'($urandom);
            wide_en = ($urandom % 4) != 0;
            v = 16'($urandom);
            if (ofs == 4'hF) v[6] = ($urandom % 4) != 0;
            if (($urandom % 2) == 0) begin
                do_wr(ofs, wd, v);
            end else begin
                case (ofs)
                    4'hC:    do_rd(wd && wide_en ? "R7 random wide" : "R3 random narrow", ofs, wd);
                    4'hD:    do_rd("R9 random hi", ofs, wd);
                    4'hE, 4'hF: do_rd("R2 random ptr", ofs, wd);
                    default: do_rd("R10 random unmapped", ofs, wd);
                endcase
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule